// File: doc/BRIEF.md
# Compact branch next-PC resolver

This unit sits at the branch stage of a 64-bit core. It accepts one 32-bit instruction word together with the address of that instruction and the two source register values already read for it. For each valid input it decides whether the instruction redirects control flow, whether the redirect is taken, and where fetch must continue. It also reports three more things: whether register 31 must be written with a return address, whether a delay-slot instruction follows, and whether the next slot is a forbidden slot that must not hold a control transfer.

Two branch families share the major-opcode space. The older family always executes one delay-slot instruction. The release-6 family of compact branches executes none. A mode input picks which family governs the shared opcodes. Several release-6 opcodes carry more than one branch. The unit tells them apart by comparing the two 5-bit register-number fields in the instruction: whether either is zero, whether they are equal, and which is larger. Results appear on registered outputs one clock after the input, and they hold until the next valid input.

Top module: `cbr_resolver`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `is_branch`, `taken`, `link_we`, `delay_slot` and `forbidden_slot` are 0 and `next_pc` is 0.
- R2: `out_valid` is `in_valid` delayed by one clock. When no valid input arrives, every result output holds its last value.
- R3: Field positions: the opcode is bits 31:26, the rs number is bits 25:21 and the rt number is bits 20:16. The target of a taken relative branch is PC + 4 + (offset << 2). The offset is sign-extended from bits 15:0, 20:0 or 25:0, depending on the branch kind.
- R4: Every older-family branch raises `delay_slot`, whether taken or not. When not taken it continues at PC + 8. Its linking forms write PC + 8 to register 31, and only when taken.
- R5: Every compact branch or jump raises `forbidden_slot`, whether taken or not, and never raises `delay_slot`. When not taken it continues at PC + 4. Its linking forms write PC + 4 to register 31, and only when taken.
- R6: Opcode 6 in release-6 mode works as follows. With an rt number of 0 it is the older-family branch on rs <= 0. With an rs number of 0 it is a compact link branch on rt <= 0. With equal numbers it is a compact link branch on rt >= 0. With any other pair it is a compact branch on unsigned rs >= rt.
- R7: Opcode 7 in release-6 mode works as follows. With an rt number of 0 it is the older-family branch on rs > 0. With an rs number of 0 it is a compact link branch on rt > 0. With equal numbers it is a compact link branch on rt < 0. With any other pair it is a compact branch on unsigned rs < rt.
- R8: Opcodes 22 and 23 in release-6 mode give compact branches without a link. An rs number of 0 gives a branch on rt <= 0 or rt > 0. Equal numbers give a branch on rt >= 0 or rt < 0. Any other pair gives a branch on signed rs >= rt or rs < rt. In older mode these opcodes are linking older-family branches on rs <= 0 and rs > 0.
- R9: Opcodes 8 and 24 in release-6 mode work as follows. If the rs number is at least the rt number, the branch is taken when the 64-bit signed sum rs + rt overflows (opcode 8) or does not overflow (opcode 24). Otherwise an rs number of 0 gives a compact link branch on rt == 0 or rt != 0, and any other pair gives a compact branch on rs == rt or rs != rt.
- R10: Opcodes 54 and 62 work as follows. With a nonzero rs number they are compact branches on rs == 0 or rs != 0, using the 21-bit offset. With an rs number of 0 they are jumps that are always taken, to rt + sign-extended bits 15:0 with no shift. The opcode 62 jump links PC + 4.
- R11: Opcodes 50 and 58 are unconditional compact branches with the 26-bit offset. Opcode 58 links PC + 4.
- R12: With `mode_r6` low, opcodes 8 and 24 are non-branches. Opcodes 6 and 7 are then older-family branches on rs <= 0 and rs > 0, whatever their rt number is.
- R13: A non-branch gives `is_branch`, `taken`, `link_we`, `delay_slot` and `forbidden_slot` all 0, and `next_pc` = PC + 4. This covers every opcode not named above, and also opcodes 22 and 23 in release-6 mode with an rt number of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| mode_r6 | input | 1 | 1 selects release-6 decoding, 0 selects the older family |
| instr | input | 32 | Instruction word |
| pc | input | 64 | Address of the instruction |
| rs_val | input | 64 | Value of the register named by bits 25:21 |
| rt_val | input | 64 | Value of the register named by bits 20:16 |
| out_valid | output | 1 | Results below belong to the input of the previous cycle |
| is_branch | output | 1 | Instruction is a branch or jump |
| taken | output | 1 | Control transfer is taken |
| next_pc | output | 64 | Address to fetch next |
| link_we | output | 1 | Write the return address to the link register |
| link_reg | output | 5 | Link register number (31) |
| link_val | output | 64 | Return address to write |
| delay_slot | output | 1 | A delay-slot instruction follows |
| forbidden_slot | output | 1 | The following slot is forbidden |

## Verification
The checker assumes that `in_valid` is low throughout reset, so the first delayed valid after reset is known. It also assumes that `pc` is sampled alongside `in_valid`, so each registered result can be related to the address of the previous cycle. The bench drives inputs only on falling edges and holds `in_valid` low during reset. It sends every instruction back to back with its own address, which keeps it within both assumptions. Operand values are picked at the signed limits, at zero and at values one step either side of them, so that overflow and comparison edges fall inside the stimulus.

// File: rtl/cbr_resolver.sv
module cbr_resolver #(
  parameter int XLEN     = 64,
  parameter int ILEN     = 32,
  parameter int LINK_IDX = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            mode_r6,
  input  logic [ILEN-1:0] instr,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic            out_valid,
  output logic            is_branch,
  output logic            taken,
  output logic [XLEN-1:0] next_pc,
  output logic            link_we,
  output logic [4:0]      link_reg,
  output logic [XLEN-1:0] link_val,
  output logic            delay_slot,
  output logic            forbidden_slot
);
  localparam logic [5:0] OP_P06  = 6'd6;
  localparam logic [5:0] OP_P07  = 6'd7;
  localparam logic [5:0] OP_P10  = 6'd8;
  localparam logic [5:0] OP_P26  = 6'd22;
  localparam logic [5:0] OP_P27  = 6'd23;
  localparam logic [5:0] OP_P30  = 6'd24;
  localparam logic [5:0] OP_BC   = 6'd50;
  localparam logic [5:0] OP_P66  = 6'd54;
  localparam logic [5:0] OP_BALC = 6'd58;
  localparam logic [5:0] OP_P76  = 6'd62;

  logic [5:0] op;
  logic [4:0] fs, ft;
  assign op = instr[ILEN-1:ILEN-6];
  assign fs = instr[25:21];
  assign ft = instr[20:16];

  logic [XLEN-1:0] x16, x21, x26, pc4, pc8, tgt16, tgt21, tgt26, jtgt, sum;
  assign x16   = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign x21   = {{(XLEN-21){instr[20]}}, instr[20:0]};
  assign x26   = {{(XLEN-26){instr[25]}}, instr[25:0]};
  assign pc4   = pc + XLEN'(4);
  assign pc8   = pc + XLEN'(8);
  assign tgt16 = pc4 + {x16[XLEN-3:0], 2'b00};
  assign tgt21 = pc4 + {x21[XLEN-3:0], 2'b00};
  assign tgt26 = pc4 + {x26[XLEN-3:0], 2'b00};
  assign jtgt  = rt_val + x16;
  assign sum   = rs_val + rt_val;

  logic ovf, s_le0, s_gt0, t_le0, t_lt0;
  assign ovf   = $signed((sum ^ rs_val) & (sum ^ rt_val)) < 0;
  assign s_le0 = $signed(rs_val) <= 0;
  assign s_gt0 = $signed(rs_val) > 0;
  assign t_le0 = $signed(rt_val) <= 0;
  assign t_lt0 = $signed(rt_val) < 0;

  logic            d_br, d_cmp, d_lnk, d_cnd;
  logic [XLEN-1:0] d_tgt;

  always_comb begin
    d_br  = 1'b0;
    d_cmp = 1'b0;
    d_lnk = 1'b0;
    d_cnd = 1'b0;
    d_tgt = tgt16;
    case (op)
      OP_P06: begin
        d_br = 1'b1;
        if (!mode_r6 || ft == 5'd0) d_cnd = s_le0;
        else begin
          d_cmp = 1'b1;
          if (fs == 5'd0)    begin d_lnk = 1'b1; d_cnd = t_le0;  end
          else if (fs == ft) begin d_lnk = 1'b1; d_cnd = !t_lt0; end
          else d_cnd = rs_val >= rt_val;
        end
      end
      OP_P07: begin
        d_br = 1'b1;
        if (!mode_r6 || ft == 5'd0) d_cnd = s_gt0;
        else begin
          d_cmp = 1'b1;
          if (fs == 5'd0)    begin d_lnk = 1'b1; d_cnd = !t_le0; end
          else if (fs == ft) begin d_lnk = 1'b1; d_cnd = t_lt0;  end
          else d_cnd = rs_val < rt_val;
        end
      end
      OP_P26, OP_P27: begin
        if (!mode_r6) begin
          d_br  = 1'b1;
          d_lnk = 1'b1;
          d_cnd = op[0] ? s_gt0 : s_le0;
        end else if (ft != 5'd0) begin
          d_br  = 1'b1;
          d_cmp = 1'b1;
          if (fs == 5'd0)    d_cnd = op[0] ? !t_le0 : t_le0;
          else if (fs == ft) d_cnd = op[0] ? t_lt0 : !t_lt0;
          else d_cnd = op[0] ? ($signed(rs_val) < $signed(rt_val))
                             : ($signed(rs_val) >= $signed(rt_val));
        end
      end
      OP_P10, OP_P30: begin
        if (mode_r6) begin
          d_br  = 1'b1;
          d_cmp = 1'b1;
          if (fs >= ft) d_cnd = ovf ^ (op == OP_P30);
          else if (fs == 5'd0) begin
            d_lnk = 1'b1;
            d_cnd = (rt_val == '0) ^ (op == OP_P30);
          end else d_cnd = (rs_val == rt_val) ^ (op == OP_P30);
        end
      end
      OP_P66, OP_P76: begin
        d_br  = 1'b1;
        d_cmp = 1'b1;
        if (fs != 5'd0) begin
          d_tgt = tgt21;
          d_cnd = (rs_val == '0) ^ (op == OP_P76);
        end else begin
          d_tgt = jtgt;
          d_cnd = 1'b1;
          d_lnk = (op == OP_P76);
        end
      end
      OP_BC, OP_BALC: begin
        d_br  = 1'b1;
        d_cmp = 1'b1;
        d_cnd = 1'b1;
        d_tgt = tgt26;
        d_lnk = (op == OP_BALC);
      end
      default: ;
    endcase
  end

  logic [XLEN-1:0] d_next;
  assign d_next = !d_br ? pc4 : d_cnd ? d_tgt : d_cmp ? pc4 : pc8;
  assign link_reg = LINK_IDX[4:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      is_branch      <= 1'b0;
      taken          <= 1'b0;
      next_pc        <= '0;
      link_we        <= 1'b0;
      link_val       <= '0;
      delay_slot     <= 1'b0;
      forbidden_slot <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        is_branch      <= d_br;
        taken          <= d_br & d_cnd;
        next_pc        <= d_next;
        link_we        <= d_br & d_lnk & d_cnd;
        link_val       <= d_cmp ? pc4 : pc8;
        delay_slot     <= d_br & ~d_cmp;
        forbidden_slot <= d_br & d_cmp;
      end
    end
  end
endmodule

// File: rtl/cbr_resolver_chk.sv
module cbr_resolver_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [XLEN-1:0] pc,
  input logic            out_valid,
  input logic            is_branch,
  input logic            taken,
  input logic [XLEN-1:0] next_pc,
  input logic            link_we,
  input logic [XLEN-1:0] link_val,
  input logic            delay_slot,
  input logic            forbidden_slot
);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(next_pc) && $stable(taken));

  p_slot_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(delay_slot && forbidden_slot));

  p_link_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> taken);

  p_legacy_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && delay_slot && !taken) |-> next_pc == $past(pc) + XLEN'(8));

  p_legacy_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && delay_slot && link_we) |-> link_val == $past(pc) + XLEN'(8));

  p_compact_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && forbidden_slot && !taken) |-> next_pc == $past(pc) + XLEN'(4));

  p_compact_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && forbidden_slot && link_we) |-> link_val == $past(pc) + XLEN'(4));

  p_nonbranch_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !is_branch) |-> (!taken && !link_we && !delay_slot &&
      !forbidden_slot && next_pc == $past(pc) + XLEN'(4)));
endmodule

bind cbr_resolver cbr_resolver_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc(pc),
  .out_valid(out_valid), .is_branch(is_branch), .taken(taken),
  .next_pc(next_pc), .link_we(link_we), .link_val(link_val),
  .delay_slot(delay_slot), .forbidden_slot(forbidden_slot)
);

// File: tb/cbr_resolver_tb_top.sv
module cbr_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        mode_r6 = 1'b1;
  logic [31:0] instr = '0;
  logic [63:0] pc = '0, rs_val = '0, rt_val = '0;
  logic        out_valid, is_branch, taken, link_we, delay_slot, forbidden_slot;
  logic [63:0] next_pc, link_val;
  logic [4:0]  link_reg;

  always #4 clk = ~clk;

  cbr_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_r6(mode_r6),
    .instr(instr), .pc(pc), .rs_val(rs_val), .rt_val(rt_val),
    .out_valid(out_valid), .is_branch(is_branch), .taken(taken),
    .next_pc(next_pc), .link_we(link_we), .link_reg(link_reg),
    .link_val(link_val), .delay_slot(delay_slot), .forbidden_slot(forbidden_slot)
  );

  typedef struct packed {
    logic        isbr, tk, dly, frb, lwe;
    logic [63:0] npc, lval;
  } exp_t;

  exp_t  q[$];
  string rq[$];
  int    n_chk = 0, n_fail = 0;
  logic [63:0] last_npc = '0;
  localparam logic [63:0] SMAX = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] SMIN = 64'h8000_0000_0000_0000;

  function automatic exp_t model(input logic v6, input logic [31:0] w,
                                 input logic [63:0] p, input logic [63:0] a,
                                 input logic [63:0] b);
    exp_t e;
    logic [5:0] op;
    logic [4:0] fs, ft;
    logic br, cmp, lnk, cnd, ovf;
    logic [63:0] tgt, t16, t21, t26;
    logic signed [63:0] sa, sb;
    logic signed [64:0] wide;
    op = w[31:26]; fs = w[25:21]; ft = w[20:16];
    sa = a; sb = b;
    wide = {sa[63], sa} + {sb[63], sb};
    ovf = wide[64] != wide[63];
    t16 = p + 64'd4 + 64'($signed(w[15:0])) * 4;
    t21 = p + 64'd4 + 64'($signed(w[20:0])) * 4;
    t26 = p + 64'd4 + 64'($signed(w[25:0])) * 4;
    br = 0; cmp = 0; lnk = 0; cnd = 0; tgt = t16;
    case (op)
      6'd6: begin
        br = 1;
        if (!v6 || ft == 0) cnd = sa <= 0;
        else begin
          cmp = 1;
          if (fs == 0) begin lnk = 1; cnd = sb <= 0; end
          else if (fs == ft) begin lnk = 1; cnd = sb >= 0; end
          else cnd = a >= b;
        end
      end
      6'd7: begin
        br = 1;
        if (!v6 || ft == 0) cnd = sa > 0;
        else begin
          cmp = 1;
          if (fs == 0) begin lnk = 1; cnd = sb > 0; end
          else if (fs == ft) begin lnk = 1; cnd = sb < 0; end
          else cnd = a < b;
        end
      end
      6'd22: begin
        if (!v6) begin br = 1; lnk = 1; cnd = sa <= 0; end
        else if (ft != 0) begin
          br = 1; cmp = 1;
          if (fs == 0) cnd = sb <= 0;
          else if (fs == ft) cnd = sb >= 0;
          else cnd = sa >= sb;
        end
      end
      6'd23: begin
        if (!v6) begin br = 1; lnk = 1; cnd = sa > 0; end
        else if (ft != 0) begin
          br = 1; cmp = 1;
          if (fs == 0) cnd = sb > 0;
          else if (fs == ft) cnd = sb < 0;
          else cnd = sa < sb;
        end
      end
      6'd8: if (v6) begin
        br = 1; cmp = 1;
        if (fs >= ft) cnd = ovf;
        else if (fs == 0) begin lnk = 1; cnd = b == 0; end
        else cnd = a == b;
      end
      6'd24: if (v6) begin
        br = 1; cmp = 1;
        if (fs >= ft) cnd = !ovf;
        else if (fs == 0) begin lnk = 1; cnd = b != 0; end
        else cnd = a != b;
      end
      6'd54: begin
        br = 1; cmp = 1;
        if (fs != 0) begin cnd = a == 0; tgt = t21; end
        else begin cnd = 1; tgt = b + 64'($signed(w[15:0])); end
      end
      6'd62: begin
        br = 1; cmp = 1;
        if (fs != 0) begin cnd = a != 0; tgt = t21; end
        else begin cnd = 1; lnk = 1; tgt = b + 64'($signed(w[15:0])); end
      end
      6'd50: begin br = 1; cmp = 1; cnd = 1; tgt = t26; end
      6'd58: begin br = 1; cmp = 1; cnd = 1; lnk = 1; tgt = t26; end
      default: ;
    endcase
    e.isbr = br;
    e.tk   = br & cnd;
    e.dly  = br & !cmp;
    e.frb  = br & cmp;
    e.lwe  = br & lnk & cnd;
    e.npc  = !br ? p + 4 : cnd ? tgt : cmp ? p + 4 : p + 8;
    e.lval = e.lwe ? (cmp ? p + 4 : p + 8) : 64'd0;
    return e;
  endfunction

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] fs,
                                      input logic [4:0] ft, input logic [15:0] im);
    return {op, fs, ft, im};
  endfunction

  task automatic send(input logic v6, input logic [31:0] w, input logic [63:0] p,
                      input logic [63:0] a, input logic [63:0] b, input string req);
    @(negedge clk);
    in_valid = 1'b1; mode_r6 = v6; instr = w; pc = p; rs_val = a; rt_val = b;
    q.push_back(model(v6, w, p, a, b));
    rq.push_back(req);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t  e, act;
      string r;
      n_chk++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 result without input: actual out_valid=1 expected 0");
      end else begin
        e = q.pop_front();
        r = rq.pop_front();
        act = {is_branch, taken, delay_slot, forbidden_slot, link_we, next_pc,
               link_we ? link_val : 64'd0};
        if (link_we && link_reg != 5'd31) act.lval = ~act.lval;
        last_npc = e.npc;
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", r, act, e);
        end
      end
    end
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] P;
    P = 64'h0000_0000_4000_1000;
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || taken !== 1'b0 || next_pc !== 64'd0 || link_we !== 1'b0 ||
        delay_slot !== 1'b0 || forbidden_slot !== 1'b0 || is_branch !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset state: actual=%b%b%h expected=00%h", out_valid, taken, next_pc, 64'd0);
    end
    @(negedge clk) rst_n = 1'b1;

    // R6 opcode 6
    send(1, enc(6, 0, 5, 16'h0010), P, 64'd9, 64'd0, "R6 link rt<=0 taken");
    send(1, enc(6, 0, 5, 16'h0010), P, 64'd9, 64'd1, "R6 link rt<=0 not taken");
    send(1, enc(6, 3, 3, 16'hFFF0), P, 64'd0, 64'd0, "R6 link rt>=0 zero");
    send(1, enc(6, 3, 3, 16'hFFF0), P, -64'sd1, -64'sd1, "R6 link rt>=0 negative");
    send(1, enc(6, 2, 3, 16'h0004), P, -64'sd1, 64'd5, "R6 unsigned rs>=rt");
    send(1, enc(6, 2, 3, 16'h0004), P, 64'd4, 64'd5, "R6 unsigned not taken");
    send(1, enc(6, 2, 0, 16'h0008), P, -64'sd3, 64'd0, "R6 R4 older rs<=0 taken");
    send(1, enc(6, 2, 0, 16'h0008), P, 64'd3, 64'd0, "R6 R4 older fall to PC+8");
    // R7 opcode 7
    send(1, enc(7, 0, 4, 16'h0002), P, 64'd0, 64'd1, "R7 link rt>0");
    send(1, enc(7, 4, 4, 16'h0002), P, 64'd0, 64'd0, "R7 link rt<0 not taken");
    send(1, enc(7, 4, 4, 16'h0002), P, SMIN, SMIN, "R7 link rt<0 taken");
    send(1, enc(7, 1, 9, 16'h0002), P, 64'd5, -64'sd1, "R7 unsigned rs<rt");
    send(1, enc(7, 1, 0, 16'h0002), P, SMAX, 64'd0, "R7 older rs>0");
    // R8 opcodes 22/23
    send(1, enc(22, 0, 4, 16'h0100), P, 64'd7, 64'd0, "R8 rt<=0 no link");
    send(1, enc(23, 6, 6, 16'h0100), P, -64'sd2, -64'sd2, "R8 rt<0");
    send(1, enc(22, 1, 2, 16'h0100), P, -64'sd1, 64'd1, "R8 signed rs>=rt not taken");
    send(1, enc(23, 1, 2, 16'h0100), P, -64'sd1, 64'd1, "R8 signed rs<rt");
    send(0, enc(22, 1, 2, 16'h0100), P, 64'd0, 64'd1, "R8 R4 older link taken");
    send(0, enc(23, 1, 2, 16'h0100), P, 64'd0, 64'd1, "R8 R4 older link not taken");
    send(1, enc(22, 5, 0, 16'h0100), P, 64'd0, 64'd0, "R13 opcode 22 rt field 0");
    // R9 opcodes 8/24
    send(1, enc(8, 5, 2, 16'h0020), P, SMAX, 64'd1, "R9 overflow max+1");
    send(1, enc(8, 5, 2, 16'h0020), P, SMAX, 64'd0, "R9 no overflow max+0");
    send(1, enc(8, 5, 5, 16'h0020), P, SMIN, -64'sd1, "R9 overflow min-1");
    send(1, enc(24, 5, 2, 16'h0020), P, SMAX, 64'd1, "R9 not-overflow with overflow");
    send(1, enc(24, 5, 2, 16'h0020), P, 64'd5, 64'd6, "R9 not-overflow taken");
    send(1, enc(8, 0, 7, 16'h0020), P, 64'd1, 64'd0, "R9 link rt==0");
    send(1, enc(24, 0, 7, 16'h0020), P, 64'd1, 64'd0, "R9 link rt!=0 not taken");
    send(1, enc(8, 2, 7, 16'h0020), P, 64'd3, 64'd3, "R9 rs==rt");
    send(1, enc(24, 2, 7, 16'h0020), P, 64'd3, 64'd4, "R9 rs!=rt");
    // R10 opcodes 54/62
    send(1, {6'd54, 5'd3, 21'h1FFFFF}, P, 64'd0, 64'd0, "R10 R3 21-bit offset -1");
    send(1, {6'd62, 5'd3, 21'h100000}, P, 64'd1, 64'd0, "R10 R3 21-bit most negative");
    send(1, {6'd54, 5'd3, 21'h000010}, P, 64'd1, 64'd0, "R10 R5 not taken PC+4");
    send(1, enc(54, 0, 4, 16'hFFF8), P, 64'd0, 64'h2000, "R10 register jump");
    send(1, enc(62, 0, 4, 16'h0006), P, 64'd0, 64'h2000, "R10 register jump link");
    // R11 opcodes 50/58
    send(1, {6'd50, 26'h2000000}, P, 64'd0, 64'd0, "R11 R3 26-bit most negative");
    send(1, {6'd58, 26'h1FFFFFF}, P, 64'd0, 64'd0, "R11 link");
    send(1, {6'd58, 26'h0000040}, P, 64'd0, 64'd0, "R11 link positive");
    // R12 older mode
    send(0, enc(8, 5, 2, 16'h0020), P, SMAX, 64'd1, "R12 opcode 8 non-branch");
    send(0, enc(24, 0, 2, 16'h0020), P, 64'd0, 64'd1, "R12 opcode 24 non-branch");
    send(0, enc(6, 0, 5, 16'h0010), P, 64'd0, 64'd9, "R12 opcode 6 older");
    send(0, enc(7, 4, 4, 16'h0010), P, 64'd0, -64'sd1, "R12 opcode 7 older");
    send(1, enc(6'd9, 1, 2, 16'h0010), P, 64'd0, 64'd0, "R13 other opcode");
    send(1, enc(6, 0, 5, 16'h8000), P, 64'd0, 64'd0, "R3 16-bit most negative");
    @(negedge clk) in_valid = 1'b0; instr = '0; pc = 64'hDEAD_0000;
    repeat (4) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || next_pc !== last_npc) begin
      n_fail++;
      $display("FAIL R2 hold: actual=%b %h expected=0 %h", out_valid, next_pc, last_npc);
    end
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 missing results: actual=%0d expected=0", q.size());
    end
    finish_run();
  end
endmodule